// File: doc/BRIEF.md
# Protected Flash Zone Access Filter

This block sits between the bus masters of a chip and one flash memory bank. It judges every access against up to `NZ` configurable protected zones and returns a grant or an error response. The processor can always fetch instructions from a zone. A processor data read of a zone is honoured only when the instruction that issued it lies in that same zone and the zone has been opened for data. The debug port and the loader can never reach a zone. When any security feature is on, an instruction fetch into the code-patch window is not serviced. Instead the filter stops and asks for a device reboot.

The filter also drives `dbg_block` high while the processor is running code from inside a zone, so that the debug link can be cut. It keeps a saturating error counter and a sticky record of the first offending address. Software can clear both.

The control is a three-state machine. `ST_IDLE` accepts a request (`req_ready` high). Transition T_ACCEPT goes from `ST_IDLE` to `ST_RESP` when the request gets a grant or an error. Transition T_TRAP goes from `ST_IDLE` to `ST_HALT` when the request is a forbidden patch fetch. Transition T_DONE goes from `ST_RESP` back to `ST_IDLE` when `rsp_ready` is high. `ST_HALT` holds `reboot_req` high until reset.

Top module: `zone_access_filter`

## Requirements
- R1: An address is in zone i when zone i is enabled and base_i <= address < base_i + size_i, computed one bit wider than the address so the sum cannot wrap. When enabled zones overlap, the lowest-numbered zone that matches decides.
- R2: An access whose address lies in no enabled zone gets `rsp_err`=0 for every master code, except for the patch-window fetch of R6.
- R3: An instruction fetch (`req_fetch`=1) by the processor (master code 0) into a zone gets `rsp_err`=0.
- R4: A processor data access (`req_fetch`=0) into zone i gets `rsp_err`=0 only when `req_pc` is in zone i by the R1 rule and bit i of `cfg_unlock` is 1. Otherwise it gets `rsp_err`=1.
- R5: Any access into a zone by master code 1 (debug), 2 (loader) or 3 (reserved) gets `rsp_err`=1, whatever `cfg_unlock` holds.
- R6: While `dbg_lock_en` is 1 or any zone is enabled, a fetch by any master into the window [PATCH_BASE, PATCH_BASE+PATCH_SIZE) produces no response. From the next cycle on, `reboot_req`=1 and `req_ready`=0 until reset. With no security active, the same fetch is granted.
- R7: `req_ready` is 1 only in `ST_IDLE`. An accepted request gives `rsp_valid`=1 on the next cycle. `rsp_valid` and `rsp_err` hold until `rsp_ready` is seen, and the filter returns to `ST_IDLE` on the following cycle.
- R8: `dbg_block` is 0 after reset. Each accepted processor fetch sets it to whether its target lay in a zone. No other access changes it.
- R9: `err_count` rises by one for every error response and saturates at 2^CNT_W-1.
- R10: The first error response sets `viol_flag` and stores its address in `viol_addr`. Both hold until `viol_clr`. `viol_clr` zeroes `viol_flag` and `err_count`. An error accepted in the same cycle as `viol_clr` is recorded after the clear.
- R11: After reset: `req_ready`=1, `rsp_valid`=0, `reboot_req`=0, `dbg_block`=0, `err_count`=0, `viol_flag`=0, `viol_addr`=0.
- R12: The decision uses the configuration present in the accept cycle. Configuration changes while a response waits do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Filter can accept a request |
| req_addr | input | AW | Target address |
| req_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| req_master | input | 2 | 0 processor, 1 debug, 2 loader, 3 reserved |
| req_pc | input | AW | Address of the instruction that issued a data access |
| cfg_base | input | NZ*AW | Zone base addresses, zone i at bits [i*AW +: AW] |
| cfg_size | input | NZ*AW | Zone sizes, same packing |
| cfg_en | input | NZ | Zone enables |
| cfg_unlock | input | NZ | Zone data-unlock bits |
| dbg_lock_en | input | 1 | Debug lock security feature active |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_err | output | 1 | 1 = error response, 0 = grant |
| dbg_block | output | 1 | Processor is executing inside a zone |
| reboot_req | output | 1 | Device reboot requested |
| err_count | output | CNT_W | Saturating error count |
| viol_flag | output | 1 | Sticky violation flag |
| viol_addr | output | AW | Address of the first violation |
| viol_clr | input | 1 | Clears the flag and the count |

## Verification
The assertions check the handshake rules on every cycle: a response holds while it waits, every accept is answered on the next cycle, and ready and response are never both high. They also check that the reboot state is terminal, that the counter never drops without a clear, and that the violation record stays fixed while flagged. Which accesses get a grant and which get an error depends on the zone layout, the unlock pattern and the issuing address. Only the bench can show that. It sweeps all zone edges, adjacent and overlapping zones, all master codes and several issuing addresses under four unlock patterns. Counter saturation, the clear racing an error, and the patch trap with and without security are also shown by bench scenarios.

// File: rtl/zaf_pkg.sv
package zaf_pkg;

    typedef enum logic [1:0] {
        MST_CPU  = 2'd0,
        MST_DBG  = 2'd1,
        MST_BOOT = 2'd2,
        MST_RSVD = 2'd3
    } master_e;

    typedef enum logic [1:0] {
        VD_OK     = 2'd0,
        VD_ERR    = 2'd1,
        VD_REBOOT = 2'd2
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RESP = 2'd1,
        ST_HALT = 2'd2
    } state_e;

endpackage

// File: rtl/zaf_zone_lookup.sv
// Finds the lowest-numbered enabled zone that contains an address.
module zaf_zone_lookup #(
    parameter int AW = 16,
    parameter int NZ = 4,
    localparam int IW = (NZ > 1) ? $clog2(NZ) : 1
) (
    input  logic [AW-1:0]    addr,
    input  logic [NZ*AW-1:0] base_flat,
    input  logic [NZ*AW-1:0] size_flat,
    input  logic [NZ-1:0]    zone_en,
    output logic             hit,
    output logic [IW-1:0]    idx
);

    logic [NZ-1:0] match;
    logic [AW:0]   addr_w;

    assign addr_w = {1'b0, addr};

    genvar g;
    generate
        for (g = 0; g < NZ; g++) begin : g_cmp
            logic [AW:0] lo;
            logic [AW:0] hi;
            assign lo = {1'b0, base_flat[g*AW +: AW]};
            assign hi = lo + {1'b0, size_flat[g*AW +: AW]};
            assign match[g] = zone_en[g] && (addr_w >= lo) && (addr_w < hi);
        end
    endgenerate

    // scanning downward leaves the lowest matching index
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = NZ - 1; i >= 0; i--) begin
            if (match[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/zaf_policy.sv
// Combinational access verdict.
module zaf_policy
    import zaf_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            NZ         = 4,
    parameter logic [AW-1:0] PATCH_BASE = 16'hE000,
    parameter logic [AW-1:0] PATCH_SIZE = 16'h1000,
    localparam int           IW         = (NZ > 1) ? $clog2(NZ) : 1
) (
    input  logic [AW-1:0] addr,
    input  logic          fetch,
    input  logic [1:0]    master,
    input  logic          tgt_hit,
    input  logic [IW-1:0] tgt_idx,
    input  logic          pc_hit,
    input  logic [IW-1:0] pc_idx,
    input  logic [NZ-1:0] unlock,
    input  logic          sec_active,
    output verdict_e      verdict
);

    localparam logic [AW:0] PATCH_LO = {1'b0, PATCH_BASE};
    localparam logic [AW:0] PATCH_HI = {1'b0, PATCH_BASE} + {1'b0, PATCH_SIZE};

    logic    in_patch;
    logic    same_zone;
    master_e who;

    assign who       = master_e'(master);
    assign in_patch  = ({1'b0, addr} >= PATCH_LO) && ({1'b0, addr} < PATCH_HI);
    assign same_zone = pc_hit && (pc_idx == tgt_idx);

    always_comb begin
        if (fetch && sec_active && in_patch) begin
            verdict = VD_REBOOT;
        end else if (!tgt_hit) begin
            verdict = VD_OK;
        end else if (who != MST_CPU) begin
            verdict = VD_ERR;
        end else if (fetch) begin
            verdict = VD_OK;
        end else if (same_zone && unlock[tgt_idx]) begin
            verdict = VD_OK;
        end else begin
            verdict = VD_ERR;
        end
    end

endmodule

// File: rtl/zaf_viol_log.sv
// Saturating error counter plus first-violation capture.
module zaf_viol_log #(
    parameter int AW    = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             log_en,
    input  logic [AW-1:0]    addr,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic [AW-1:0]    first_addr
);

    logic [CNT_W-1:0] cnt_base;
    logic             flag_base;

    assign cnt_base  = clr ? '0 : count;
    assign flag_base = clr ? 1'b0 : flag;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            flag       <= 1'b0;
            first_addr <= '0;
        end else if (log_en) begin
            count <= (&cnt_base) ? cnt_base : cnt_base + 1'b1;
            flag  <= 1'b1;
            if (!flag_base) first_addr <= addr;
        end else begin
            count <= cnt_base;
            flag  <= flag_base;
        end
    end

endmodule

// File: rtl/zone_access_filter.sv
// Protected flash zone access filter: request FSM and response registers.
module zone_access_filter
    import zaf_pkg::*;
#(
    parameter int            AW         = 16,
    parameter int            NZ         = 4,
    parameter int            CNT_W      = 16,
    parameter logic [AW-1:0] PATCH_BASE = 16'hE000,
    parameter logic [AW-1:0] PATCH_SIZE = 16'h1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_fetch,
    input  logic [1:0]       req_master,
    input  logic [AW-1:0]    req_pc,
    input  logic [NZ*AW-1:0] cfg_base,
    input  logic [NZ*AW-1:0] cfg_size,
    input  logic [NZ-1:0]    cfg_en,
    input  logic [NZ-1:0]    cfg_unlock,
    input  logic             dbg_lock_en,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic             rsp_err,
    output logic             dbg_block,
    output logic             reboot_req,
    output logic [CNT_W-1:0] err_count,
    output logic             viol_flag,
    output logic [AW-1:0]    viol_addr,
    input  logic             viol_clr
);

    localparam int IW = (NZ > 1) ? $clog2(NZ) : 1;

    state_e        state, state_nx;
    verdict_e      verdict;
    logic          tgt_hit, pc_hit;
    logic [IW-1:0] tgt_idx, pc_idx;
    logic          accept;
    logic          sec_active;
    logic          rsp_err_q;
    logic          dbg_q;

    assign sec_active = dbg_lock_en | (|cfg_en);
    assign accept     = req_valid && req_ready;

    zaf_zone_lookup #(.AW(AW), .NZ(NZ)) u_tgt (
        .addr      (req_addr),
        .base_flat (cfg_base),
        .size_flat (cfg_size),
        .zone_en   (cfg_en),
        .hit       (tgt_hit),
        .idx       (tgt_idx)
    );

    zaf_zone_lookup #(.AW(AW), .NZ(NZ)) u_pc (
        .addr      (req_pc),
        .base_flat (cfg_base),
        .size_flat (cfg_size),
        .zone_en   (cfg_en),
        .hit       (pc_hit),
        .idx       (pc_idx)
    );

    zaf_policy #(
        .AW(AW), .NZ(NZ), .PATCH_BASE(PATCH_BASE), .PATCH_SIZE(PATCH_SIZE)
    ) u_pol (
        .addr       (req_addr),
        .fetch      (req_fetch),
        .master     (req_master),
        .tgt_hit    (tgt_hit),
        .tgt_idx    (tgt_idx),
        .pc_hit     (pc_hit),
        .pc_idx     (pc_idx),
        .unlock     (cfg_unlock),
        .sec_active (sec_active),
        .verdict    (verdict)
    );

    zaf_viol_log #(.AW(AW), .CNT_W(CNT_W)) u_log (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (viol_clr),
        .log_en     (accept && (verdict == VD_ERR)),
        .addr       (req_addr),
        .count      (err_count),
        .flag       (viol_flag),
        .first_addr (viol_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: T_ACCEPT, T_TRAP, T_DONE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = (verdict == VD_REBOOT) ? ST_HALT : ST_RESP;
            ST_RESP: if (rsp_ready) state_nx = ST_IDLE;
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        req_ready  = 1'b0;
        rsp_valid  = 1'b0;
        reboot_req = 1'b0;
        unique case (state)
            ST_IDLE: req_ready  = 1'b1;
            ST_RESP: rsp_valid  = 1'b1;
            ST_HALT: reboot_req = 1'b1;
            default: req_ready  = 1'b0;
        endcase
    end

    // decision captured at accept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_err_q <= 1'b0;
            dbg_q     <= 1'b0;
        end else if (accept) begin
            rsp_err_q <= (verdict == VD_ERR);
            if (master_e'(req_master) == MST_CPU && req_fetch && verdict != VD_REBOOT)
                dbg_q <= tgt_hit;
        end
    end

    assign rsp_err   = rsp_err_q;
    assign dbg_block = dbg_q;

endmodule

// File: rtl/zaf_checker.sv
module zaf_checker #(
    parameter int AW    = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic             rsp_err,
    input logic             reboot_req,
    input logic [CNT_W-1:0] err_count,
    input logic             viol_flag,
    input logic [AW-1:0]    viol_addr,
    input logic             viol_clr
);

    assert_rsp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err)));

    assert_accept_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || reboot_req));

    assert_ready_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && rsp_valid));

    assert_reboot_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reboot_req |=> (reboot_req && !req_ready && !rsp_valid));

    assert_count_mono_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_clr |=> (err_count >= $past(err_count)));

    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !viol_clr) |=> (viol_flag && $stable(viol_addr)));

endmodule

bind zone_access_filter zaf_checker #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_err    (rsp_err),
    .reboot_req (reboot_req),
    .err_count  (err_count),
    .viol_flag  (viol_flag),
    .viol_addr  (viol_addr),
    .viol_clr   (viol_clr)
);

// File: tb/sim_zone_access_filter.sv
`timescale 1ns/1ps
module sim_zone_access_filter;

    localparam int AW = 16;
    localparam int NZ = 4;
    localparam int CW = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [AW-1:0]   req_addr = '0;
    logic            req_fetch = 1'b0;
    logic [1:0]      req_master = '0;
    logic [AW-1:0]   req_pc = '0;
    logic [NZ*AW-1:0] cfg_base = '0;
    logic [NZ*AW-1:0] cfg_size = '0;
    logic [NZ-1:0]   cfg_en = '0;
    logic [NZ-1:0]   cfg_unlock = '0;
    logic            dbg_lock_en = 1'b0;
    logic            rsp_valid;
    logic            rsp_ready = 1'b0;
    logic            rsp_err;
    logic            dbg_block;
    logic            reboot_req;
    logic [CW-1:0]   err_count;
    logic            viol_flag;
    logic [AW-1:0]   viol_addr;
    logic            viol_clr = 1'b0;

    always #2.5 clk = ~clk;

    zone_access_filter #(
        .AW(AW), .NZ(NZ), .CNT_W(CW), .PATCH_BASE(16'hE000), .PATCH_SIZE(16'h1000)
    ) u0 (.*);

    int vecs = 0;
    int fails = 0;
    bit done = 1'b0;

    int zb[4];
    int zs[4];
    bit ze[4];
    bit [3:0] um;
    bit m_dbg;
    int m_cnt;
    bit m_flag;
    int m_faddr;

    task automatic chk(input string tag, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int zone_of(input int a);
        for (int i = 0; i < 4; i++)
            if (ze[i] && a >= zb[i] && a < zb[i] + zs[i]) return i;
        return -1;
    endfunction

    function automatic int zone_hits(input int a);
        int n = 0;
        for (int i = 0; i < 4; i++)
            if (ze[i] && a >= zb[i] && a < zb[i] + zs[i]) n++;
        return n;
    endfunction

    task automatic apply_cfg();
        for (int i = 0; i < 4; i++) begin
            cfg_base[i*AW +: AW] = zb[i][AW-1:0];
            cfg_size[i*AW +: AW] = zs[i][AW-1:0];
            cfg_en[i]            = ze[i];
        end
        cfg_unlock = um;
    endtask

    task automatic model_log(input bit e, input int a);
        if (e) begin
            if (m_cnt < CMAX) m_cnt++;
            if (!m_flag) begin m_flag = 1'b1; m_faddr = a; end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_dbg = 0; m_cnt = 0; m_flag = 0; m_faddr = 0;
    endtask

    task automatic do_vec(input int a, input bit f, input int m, input int pc, input bit hold);
        int  t;
        bit  e;
        string tag;
        @(negedge clk);
        chk("R7 ready idle", int'(req_ready), 1);
        t = zone_of(a);
        if (t < 0) begin e = 0; tag = "R2"; end
        else if (m != 0) begin e = 1; tag = "R5"; end
        else if (f) begin e = 0; tag = "R3"; end
        else begin e = !((zone_of(pc) == t) && um[t]); tag = "R4"; end
        if (zone_hits(a) > 1) tag = {tag, "/R1 overlap"};
        req_valid = 1'b1; req_addr = a[AW-1:0]; req_fetch = f;
        req_master = m[1:0]; req_pc = pc[AW-1:0];
        @(negedge clk);
        req_valid = 1'b0;
        if (m == 0 && f) m_dbg = (t >= 0);
        model_log(e, a);
        chk("R7 rsp_valid", int'(rsp_valid), 1);
        chk(tag, int'(rsp_err), int'(e));
        chk("R8 dbg_block", int'(dbg_block), int'(m_dbg));
        chk("R9 err_count", int'(err_count), m_cnt);
        chk("R10 viol_flag", int'(viol_flag), int'(m_flag));
        chk("R10 viol_addr", int'(viol_addr), m_faddr);
        if (hold) begin
            cfg_unlock = ~um;
            cfg_en     = ~cfg_en;
            @(negedge clk);
            chk("R12 held rsp_valid", int'(rsp_valid), 1);
            chk("R12 held rsp_err", int'(rsp_err), int'(e));
            apply_cfg();
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R7 rsp drop", int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        int alist[18];
        int plist[5];
        int k;
        zb = '{16'h1000, 16'h1800, 16'h4000, 16'h6000};
        zs = '{16'h0800, 16'h0800, 16'h0100, 16'h0100};
        ze = '{0, 0, 0, 0};
        um = 4'h0;
        apply_cfg();
        do_reset();
        @(negedge clk);
        chk("R11 req_ready", int'(req_ready), 1);
        chk("R11 rsp_valid", int'(rsp_valid), 0);
        chk("R11 reboot_req", int'(reboot_req), 0);
        chk("R11 dbg_block", int'(dbg_block), 0);
        chk("R11 err_count", int'(err_count), 0);
        chk("R11 viol_flag", int'(viol_flag), 0);
        chk("R11 viol_addr", int'(viol_addr), 0);

        // no security active: patch fetch is an ordinary granted access
        do_vec(16'hE010, 1'b1, 0, 16'h0200, 1'b0);
        chk("R6 no reboot without security", int'(reboot_req), 0);

        k = 0;
        for (int ph = 0; ph < 2; ph++) begin
            if (ph == 0) begin
                ze = '{1, 1, 1, 0}; zb[3] = 16'h6000;
            end else begin
                ze = '{1, 1, 1, 1}; zb[3] = 16'h4080;
            end
            for (int i = 0; i < 4; i++) begin
                alist[4*i]     = zb[i] - 1;
                alist[4*i + 1] = zb[i];
                alist[4*i + 2] = zb[i] + zs[i] - 1;
                alist[4*i + 3] = zb[i] + zs[i];
                plist[i]       = zb[i] + 1;
            end
            alist[16] = 0;
            alist[17] = 16'h7FFF;
            plist[4]  = 16'h0200;
            for (int u = 0; u < 4; u++) begin
                um = (u == 0) ? 4'h0 : (u == 1) ? 4'hF : (u == 2) ? 4'h5 : 4'hA;
                apply_cfg();
                for (int ai = 0; ai < 18; ai++)
                    for (int m = 0; m < 4; m++)
                        for (int f = 0; f < 2; f++)
                            for (int pi = 0; pi < 5; pi++) begin
                                k++;
                                do_vec(alist[ai], f[0], m, plist[pi], (k % 7) == 0);
                            end
            end
            // data access into the patch window is allowed with security on
            do_vec(16'hE020, 1'b0, 0, 16'h0200, 1'b0);
        end
        chk("R9 saturated", int'(err_count), CMAX);

        // software clear
        @(negedge clk);
        viol_clr = 1'b1;
        @(negedge clk);
        viol_clr = 1'b0;
        m_cnt = 0; m_flag = 0;
        chk("R10 clear count", int'(err_count), 0);
        chk("R10 clear flag", int'(viol_flag), 0);

        // clear racing an error: debug read of zone 0
        @(negedge clk);
        viol_clr = 1'b1; req_valid = 1'b1; req_addr = 16'h1234;
        req_fetch = 1'b0; req_master = 2'd1; req_pc = 16'h0200;
        @(negedge clk);
        viol_clr = 1'b0; req_valid = 1'b0;
        chk("R10 race err", int'(rsp_err), 1);
        chk("R10 race count", int'(err_count), 1);
        chk("R10 race flag", int'(viol_flag), 1);
        chk("R10 race addr", int'(viol_addr), 16'h1234);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;

        // forbidden patch fetch with debug lock alone
        ze = '{0, 0, 0, 0}; apply_cfg(); dbg_lock_en = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'hEFFF; req_fetch = 1'b1;
        req_master = 2'd0; req_pc = 16'h0200;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R6 reboot raised", int'(reboot_req), 1);
        chk("R6 no response", int'(rsp_valid), 0);
        chk("R6 ready low", int'(req_ready), 0);
        rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        rsp_ready = 1'b0;
        chk("R6 reboot held", int'(reboot_req), 1);
        do_reset();
        dbg_lock_en = 1'b0;
        @(negedge clk);
        chk("R11 reboot cleared", int'(reboot_req), 0);
        chk("R11 ready again", int'(req_ready), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule